// File: doc/BRIEF.md
# Shared Multi-Channel FIFO Pool

This block holds the data of several DMA channels in one storage array. To each channel the array looks like a private first-in, first-out queue whose depth is not fixed: a channel grows by taking any free entry and shrinks as its entries are read out. The only limit is the pool as a whole. The sum of all channel occupancies never exceeds the pool capacity. Free entries go to whichever channel pushes first, and no channel has a reserved quota. Each entry is as wide as the memory-bus data path.

The load side offers one push port shared by all channels, with a channel select. The store side offers one pop port with a channel select. A push and a pop may both complete in the same cycle. Each channel keeps a linked chain of entries, so its data may lie anywhere in the array. Entries that are released go onto a recycle queue and are reused later. A per-channel flush walks one channel's chain and releases one entry per cycle until that channel is empty. The block reports the pool's free count and the occupancy and empty state of every channel.

Top module: `shared_fifo_pool`

## Requirements
- R1: After reset `free_count` equals DEPTH and every channel count is zero. At all times `free_count` plus the sum of all channel counts equals DEPTH.
- R2: `push_ready` is 1 exactly when no flush is in progress and `free_count` is nonzero. This holds whatever the occupancy of the selected channel. A push offered while `push_ready` is 0 changes no state.
- R3: The data popped from a channel comes out in the order it was pushed to that channel, whatever traffic the other channels carry in between.
- R4: `pop_ready` is 1 exactly when no flush is in progress and the channel selected by `pop_ch` holds at least one entry. A pop offered while `pop_ready` is 0 changes no state.
- R5: `pop_dvalid` is 1 in the cycle after an accepted pop, and `pop_data` then carries the popped word. In every other cycle `pop_dvalid` is 0.
- R6: When a push and a pop are accepted in the same cycle, `free_count` is unchanged and the two channel counts move by +1 and -1. This also holds when both target one channel that holds a single entry.
- R7: A `flush_req` taken while `flush_busy` is 0 lets the push and pop of that same cycle complete. From the next cycle, `flush_busy` stays 1 for max(n,1) cycles, where n is the channel's count at that point. Each of those cycles returns one of the channel's entries to the pool. When the flush ends, the channel is empty. A `flush_req` seen while busy is ignored.
- R8: Entries that have been released can be reused. After any traffic, one channel alone can take every entry of the pool, at which point `free_count` is 0.
- R9: The count of channel c is at `ch_count[c*CW +: CW]`, with CW = clog2(DEPTH+1). Bit c of `ch_empty` is 1 exactly when that count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push offered |
| push_ch | input | CHW | Channel that receives the push |
| push_data | input | WIDTH | Word to store |
| push_ready | output | 1 | Push accepted this cycle when valid |
| pop_valid | input | 1 | Pop offered |
| pop_ch | input | CHW | Channel to read from |
| pop_ready | output | 1 | Pop accepted this cycle when valid |
| pop_dvalid | output | 1 | Registered: pop_data valid |
| pop_data | output | WIDTH | Registered word from the last accepted pop |
| flush_req | input | 1 | Request to empty a channel |
| flush_ch | input | CHW | Channel to flush |
| flush_busy | output | 1 | Flush in progress; push and pop stalled |
| free_count | output | CW | Unused entries in the pool |
| ch_count | output | NCH*CW | Per-channel occupancy, CW bits each |
| ch_empty | output | NCH | Per-channel empty flags |

## Verification
The bench builds the block with four channels, a 16-entry pool and 16-bit words. With these values, a single channel can exhaust the whole pool within a few cycles. The recycle queue also wraps many times during the long mixed-traffic run, so chains are soon scattered through the array. A flush can then start on a channel of any length while the others keep their data, and the push on an empty channel is refused because the pool is full.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  typedef enum logic {
    SFP_RUN   = 1'b0,
    SFP_FLUSH = 1'b1
  } sfp_state_e;
endpackage

// File: rtl/sfp_free_alloc.sv
module sfp_free_alloc #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          give,
  input  logic [AW-1:0] give_idx,
  output logic [AW-1:0] alloc_idx,
  output logic [CW-1:0] free_cnt
);
  // Entries never handed out yet come from a counter; released ones from a ring.
  logic [CW-1:0] fresh;
  logic [CW-1:0] rec_lvl;
  logic [AW-1:0] wptr, rptr;
  logic [AW-1:0] rec_mem [DEPTH];
  logic          fresh_left;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign fresh_left = (fresh < CW'(DEPTH));
  assign alloc_idx  = fresh_left ? fresh[AW-1:0] : rec_mem[rptr];

  always_ff @(posedge clk) begin
    if (give) rec_mem[wptr] <= give_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fresh    <= '0;
      rec_lvl  <= '0;
      wptr     <= '0;
      rptr     <= '0;
      free_cnt <= CW'(DEPTH);
    end else begin
      if (take && fresh_left) fresh <= fresh + 1'b1;
      if (take && !fresh_left) rptr <= bump(rptr);
      if (give) wptr <= bump(wptr);
      rec_lvl  <= rec_lvl + CW'(give) - CW'(take && !fresh_left);
      free_cnt <= free_cnt + CW'(give) - CW'(take);
    end
  end

  AST_TAKE_HAS_FREE: assert property (@(posedge clk) disable iff (rst)
    take |-> (free_cnt != '0)); // R2
  AST_FREE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    free_cnt == CW'(DEPTH) - fresh + rec_lvl); // R1
endmodule

// File: rtl/sfp_link_ram.sv
module sfp_link_ram #(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [AW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [AW-1:0] rdata
);
  logic [AW-1:0] nxt [DEPTH];

  always_ff @(posedge clk) begin
    if (we) nxt[waddr] <= wdata;
  end

  assign rdata = nxt[raddr];
endmodule

// File: rtl/sfp_data_ram.sv
module sfp_data_ram #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/shared_fifo_pool.sv
module shared_fifo_pool
  import sfp_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DEPTH = 512,
  parameter int WIDTH = 64,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW  = $clog2(DEPTH),
  localparam int CW  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  input  logic [CHW-1:0]    push_ch,
  input  logic [WIDTH-1:0]  push_data,
  output logic              push_ready,
  input  logic              pop_valid,
  input  logic [CHW-1:0]    pop_ch,
  output logic              pop_ready,
  output logic              pop_dvalid,
  output logic [WIDTH-1:0]  pop_data,
  input  logic              flush_req,
  input  logic [CHW-1:0]    flush_ch,
  output logic              flush_busy,
  output logic [CW-1:0]     free_count,
  output logic [NCH*CW-1:0] ch_count,
  output logic [NCH-1:0]    ch_empty
);
  sfp_state_e    st;
  logic [CHW-1:0] fch;
  logic [AW-1:0] head_q [NCH];
  logic [AW-1:0] tail_q [NCH];
  logic [CW-1:0] cnt_q  [NCH];

  logic          flushing, push_go, pop_go, fr_go;
  logic [CHW-1:0] fr_ch;
  logic [AW-1:0] alloc_idx, fr_idx, link_rd, new_head;

  assign flushing   = (st == SFP_FLUSH);
  assign flush_busy = flushing;
  assign push_ready = !flushing && (free_count != '0);
  assign pop_ready  = !flushing && (cnt_q[pop_ch] != '0);
  assign push_go    = push_valid && push_ready;
  assign pop_go     = pop_valid && pop_ready;

  // Release path: the flush walker owns it while busy, the pop port otherwise.
  assign fr_ch  = flushing ? fch : pop_ch;
  assign fr_go  = flushing ? (cnt_q[fch] != '0) : pop_go;
  assign fr_idx = head_q[fr_ch];
  assign new_head = (push_go && (push_ch == fr_ch) && (cnt_q[fr_ch] == CW'(1)))
                    ? alloc_idx : link_rd;

  sfp_free_alloc #(.DEPTH(DEPTH)) u_free (
    .clk(clk), .rst(rst), .take(push_go), .give(fr_go), .give_idx(fr_idx),
    .alloc_idx(alloc_idx), .free_cnt(free_count)
  );

  sfp_link_ram #(.DEPTH(DEPTH)) u_link (
    .clk(clk), .we(push_go && (cnt_q[push_ch] != '0)),
    .waddr(tail_q[push_ch]), .wdata(alloc_idx),
    .raddr(fr_idx), .rdata(link_rd)
  );

  sfp_data_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .clk(clk), .we(push_go), .waddr(alloc_idx), .wdata(push_data),
    .re(pop_go), .raddr(head_q[pop_ch]), .rdata(pop_data)
  );

  always_ff @(posedge clk) begin
    if (rst) pop_dvalid <= 1'b0;
    else     pop_dvalid <= pop_go;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= SFP_RUN;
      fch <= '0;
    end else begin
      case (st)
        SFP_RUN: if (flush_req) begin
          st  <= SFP_FLUSH;
          fch <= flush_ch;
        end
        SFP_FLUSH: if (cnt_q[fch] <= CW'(1)) st <= SFP_RUN;
        default: st <= SFP_RUN;
      endcase
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic push_hit, fr_hit;
    assign push_hit = push_go && (push_ch == CHW'(c));
    assign fr_hit   = fr_go && (fr_ch == CHW'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[c]  <= '0;
        head_q[c] <= '0;
        tail_q[c] <= '0;
      end else begin
        cnt_q[c] <= cnt_q[c] + CW'(push_hit) - CW'(fr_hit);
        if (push_hit) tail_q[c] <= alloc_idx;
        if (push_hit && (cnt_q[c] == '0)) head_q[c] <= alloc_idx;
        else if (fr_hit)                  head_q[c] <= new_head;
      end
    end

    assign ch_count[c*CW +: CW] = cnt_q[c];
    assign ch_empty[c]          = (cnt_q[c] == '0);

    AST_SINGLE_HEAD_TAIL: assert property (@(posedge clk) disable iff (rst)
      (cnt_q[c] == CW'(1)) |-> (head_q[c] == tail_q[c])); // R3
  end

  int occ_sum;
  always_comb begin
    occ_sum = 0;
    for (int c = 0; c < NCH; c++) occ_sum += int'(cnt_q[c]);
  end

  AST_POOL_CONSERVED: assert property (@(posedge clk) disable iff (rst)
    (int'(free_count) + occ_sum) == DEPTH); // R1
  AST_FLUSH_STEP: assert property (@(posedge clk) disable iff (rst)
    (flushing && (cnt_q[fch] != '0)) |=> (cnt_q[fch] == $past(cnt_q[fch]) - CW'(1))); // R7
endmodule

// File: tb/test_shared_fifo_pool.sv
module test_shared_fifo_pool;
  localparam int NCH = 4, DEPTH = 16, WIDTH = 16;
  localparam int CHW = $clog2(NCH), CW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic push_valid = 0, pop_valid = 0, flush_req = 0;
  logic [CHW-1:0] push_ch = '0, pop_ch = '0, flush_ch = '0;
  logic [WIDTH-1:0] push_data = '0;
  logic push_ready, pop_ready, pop_dvalid, flush_busy;
  logic [WIDTH-1:0] pop_data;
  logic [CW-1:0] free_count;
  logic [NCH*CW-1:0] ch_count;
  logic [NCH-1:0] ch_empty;

  always #2 clk = ~clk;

  shared_fifo_pool #(.NCH(NCH), .DEPTH(DEPTH), .WIDTH(WIDTH)) i_shared_fifo_pool (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_ch(push_ch),
    .push_data(push_data), .push_ready(push_ready), .pop_valid(pop_valid),
    .pop_ch(pop_ch), .pop_ready(pop_ready), .pop_dvalid(pop_dvalid),
    .pop_data(pop_data), .flush_req(flush_req), .flush_ch(flush_ch),
    .flush_busy(flush_busy), .free_count(free_count), .ch_count(ch_count),
    .ch_empty(ch_empty)
  );

  int checks = 0, errors = 0;
  logic [WIDTH-1:0] mq [NCH][$];
  int mfree = DEPTH, mfch = 0;
  bit mbusy = 0, exp_dv = 0, last_pp = 0;
  logic [WIDTH-1:0] exp_d = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    check(int'(free_count) == mfree, last_pp ? "R6" : "R1", "free_count",
          int'(free_count), mfree);
    for (int c = 0; c < NCH; c++) begin
      check(int'(ch_count[c*CW +: CW]) == mq[c].size(), "R9", "ch_count",
            int'(ch_count[c*CW +: CW]), mq[c].size());
      check(ch_empty[c] == (mq[c].size() == 0), "R9", "ch_empty",
            int'(ch_empty[c]), int'(mq[c].size() == 0));
    end
    check(flush_busy == mbusy, "R7", "flush_busy", int'(flush_busy), int'(mbusy));
    check(pop_dvalid == exp_dv, "R5", "pop_dvalid", int'(pop_dvalid), int'(exp_dv));
    if (exp_dv)
      check(pop_data == exp_d, "R3", "pop_data", int'(pop_data), int'(exp_d));
    check(push_ready == (!mbusy && mfree > 0), "R2", "push_ready",
          int'(push_ready), int'(!mbusy && mfree > 0));
    check(pop_ready == (!mbusy && mq[pop_ch].size() > 0), "R4", "pop_ready",
          int'(pop_ready), int'(!mbusy && mq[pop_ch].size() > 0));
  endtask

  task automatic step(input bit pv, input int pch, input logic [WIDTH-1:0] pd,
                      input bit ov, input int och, input bit fr, input int fc);
    bit pf, of;
    @(negedge clk);
    push_valid = pv; push_ch = CHW'(pch); push_data = pd;
    pop_valid = ov; pop_ch = CHW'(och);
    flush_req = fr; flush_ch = CHW'(fc);
    #1;
    compare();
    exp_dv = 0; last_pp = 0;
    if (mbusy) begin
      if (mq[mfch].size() > 0) begin
        void'(mq[mfch].pop_front());
        mfree++;
      end
      if (mq[mfch].size() == 0) mbusy = 0;
    end else begin
      pf = pv && (mfree > 0);
      of = ov && (mq[och].size() > 0);
      if (of) begin
        exp_d = mq[och].pop_front();
        exp_dv = 1;
        mfree++;
      end
      if (pf) begin
        mq[pch].push_back(pd);
        mfree--;
      end
      last_pp = pf && of;
      if (fr) begin
        mbusy = 1;
        mfch = fc;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, '0, 0, 0, 0, 0);
  endtask

  task automatic drain_all();
    for (int c = 0; c < NCH; c++)
      while (mq[c].size() > 0) step(0, 0, '0, 1, c, 0, 0);
    idle(1);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    idle(1); // R1 reset state

    // R8/R2: one channel takes the whole pool, others are then refused
    for (int i = 0; i < DEPTH; i++) step(1, 0, WIDTH'(16'h100 + i), 0, 0, 0, 0);
    idle(1);
    check(free_count == '0, "R8", "free_count full", int'(free_count), 0);
    step(1, 2, 16'hdead, 0, 0, 0, 0); // refused push on empty channel, R2
    idle(1);
    check(ch_count[2*CW +: CW] == '0, "R2", "refused push count",
          int'(ch_count[2*CW +: CW]), 0);
    // R3: drain in order
    for (int i = 0; i < DEPTH; i++) step(0, 0, '0, 1, 0, 0, 0);
    idle(1);
    step(0, 0, '0, 1, 1, 0, 0); // R4 pop on empty channel ignored
    idle(1);

    // R6: push and pop on one channel holding a single entry
    step(1, 2, 16'h0aa1, 0, 0, 0, 0);
    step(1, 2, 16'h0aa2, 1, 2, 0, 0);
    step(1, 1, 16'h0bb1, 1, 2, 0, 0);
    idle(2);

    // R7: flush with traffic in the request cycle and a request while busy
    for (int i = 0; i < 5; i++) step(1, 1, WIDTH'(16'h200 + i), 0, 0, 0, 0);
    step(1, 3, 16'h0333, 1, 1, 1, 1);
    step(1, 3, 16'h0334, 1, 3, 1, 3);
    idle(6);
    check(ch_count[1*CW +: CW] == '0, "R7", "flushed count",
          int'(ch_count[1*CW +: CW]), 0);
    step(0, 0, '0, 0, 0, 1, 0); // flush of an empty channel: one busy cycle
    idle(2);

    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      step(r < 60, $urandom_range(0, NCH - 1), WIDTH'($urandom),
           ($urandom_range(0, 99) < 50), $urandom_range(0, NCH - 1),
           (r == 7), $urandom_range(0, NCH - 1));
    end
    while (mbusy) idle(1);
    drain_all();

    // R8: full reuse after heavy recycling
    for (int i = 0; i < DEPTH; i++) step(1, 3, WIDTH'(16'h400 + i), 0, 0, 0, 0);
    idle(1);
    check(free_count == '0, "R8", "free_count after reuse", int'(free_count), 0);
    drain_all();

    summary();
    $finish;
  end
endmodule